// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is a local timer of the kind placed next to each processor core. Its first stage is a prescaler. It divides the incoming timer clock enable into ticks. Its second stage is a down-counter that counts those ticks and raises an interrupt flag when the programmed number of ticks has passed. The counter can work in one-shot form, where it stops at zero after one event. It can also work in interval form, where it reloads from its period buffer and keeps firing until software stops it.

Software reaches the timer over a 32-bit register bus with single-cycle writes and a combinational read port. Each write to one of the three timing registers sets its own "write applied" flag, and software clears that flag by writing 1 to it. Each stage has its own run bit. A write to the period buffer loads the live counter only when the update-request bit (bit 31) is set. This lets software queue a new reload value without disturbing the count in progress.

Top module: `per_core_tick_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: While the tick stage runs with the divisor register at N, it produces one tick on every (N+1)-th cycle in which `tclk_en` is high. With a period count C, the first interrupt appears C·(N+1) enabled cycles after the start edge.
- R3: A write to the period register at offset 0x08 stores bits 30:0 as the reload value, and bit 31 always reads back as 0. The live counter is loaded as well only when bit 31 of the written word is 1. A load on the same edge as a tick takes precedence over the tick's decrement.
- R4: When control bit 2 is 0 (one-shot), the counter sets the flag once when it reaches zero and stays at zero. No further interrupt follows.
- R5: When control bit 2 is 1 (interval), the counter reloads from the period buffer on each expiry, so the flag sets again every C ticks.
- R6: Control register at offset 0x20: bit 0 runs the tick stage and bit 1 runs the period counter. Clearing both freezes both counters at their current values, and setting them again resumes from those held values.
- R7: No counting happens in a cycle where `tclk_en` is low.
- R8: Bit 0 of the flag register at offset 0x30 is set by an expiry and cleared by writing 1. If both happen on the same edge, the set wins. `irq` is high when that flag and bit 0 of the enable register at offset 0x34 are both 1.
- R9: In the write-applied register at offset 0x40, bit 0 is set by a write to offset 0x00, bit 1 by a write to 0x08 and bit 3 by a write to 0x20. Each bit is cleared by writing 1 to it, and the other bits read 0.
- R10: A period counter holding 0 does not count and never raises the flag, even while running in interval form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tclk_en | input | 1 | Timer clock enable; one count opportunity per high cycle |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt: flag AND enable |

## Verification
A wrong value held in the prescaler or in the period counter shows at the ports as an interrupt that comes early or late. The error in edges is exact and predictable, so each delay is compared with C·(N+1) on the very cycle it should occur. A lost reload shows up by the second interval period as a missing or misplaced interrupt. A counter that fails to freeze shows up on the first edge after restart. Errors in the flags and the write-applied bits show on the next read at their offset.

// File: rtl/tick_timer_pkg.sv
// Shared register offsets and control field layout for the per-core tick timer.
// Assumes a byte-addressed bus; offsets are compared after width adaption.
package tick_timer_pkg;
    localparam logic [7:0] OFS_DIV    = 8'h00;
    localparam logic [7:0] OFS_PERIOD = 8'h08;
    localparam logic [7:0] OFS_CTRL   = 8'h20;
    localparam logic [7:0] OFS_FLAG   = 8'h30;
    localparam logic [7:0] OFS_IEN    = 8'h34;
    localparam logic [7:0] OFS_WDONE  = 8'h40;

    localparam int WD_DIV_BIT    = 0;
    localparam int WD_PERIOD_BIT = 1;
    localparam int WD_CTRL_BIT   = 3;

    // packed MSB first: tick_run is bit 0, per_run bit 1, interval bit 2
    typedef struct packed {
        logic interval;
        logic per_run;
        logic tick_run;
    } ctrl_t;
endpackage

// File: rtl/tick_timer_regs.sv
// Register file: decodes bus writes, holds buffers, control, flag, enable and
// write-applied bits, and drives the combinational read mux.
// Assumes one write per cycle; a flag set by expiry wins over a clear.
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int PRE_W = 32,
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             expire,
    output logic             div_load,
    output logic             per_load,
    output logic [PRE_W-1:0] div_buf,
    output logic [CNT_W-1:0] per_buf,
    output ctrl_t            ctrl,
    output logic             flag,
    output logic             ien
);
    localparam int UPD_BIT = DW - 1;

    logic wr_div, wr_per, wr_ctrl, wr_flag, wr_ien, wr_wdone;
    logic wd_div, wd_per, wd_ctrl;

    // Address decode of the write strobe
    always_comb begin
        wr_div   = bus_wr && (bus_addr == AW'(OFS_DIV));
        wr_per   = bus_wr && (bus_addr == AW'(OFS_PERIOD));
        wr_ctrl  = bus_wr && (bus_addr == AW'(OFS_CTRL));
        wr_flag  = bus_wr && (bus_addr == AW'(OFS_FLAG));
        wr_ien   = bus_wr && (bus_addr == AW'(OFS_IEN));
        wr_wdone = bus_wr && (bus_addr == AW'(OFS_WDONE));
    end

    assign div_load = wr_div;
    assign per_load = wr_per && bus_wdata[UPD_BIT];

    // Writable registers and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_buf <= '0;
            per_buf <= '0;
            ctrl    <= '0;
            flag    <= 1'b0;
            ien     <= 1'b0;
            wd_div  <= 1'b0;
            wd_per  <= 1'b0;
            wd_ctrl <= 1'b0;
        end else begin
            if (wr_div)  div_buf <= bus_wdata[PRE_W-1:0];
            if (wr_per)  per_buf <= bus_wdata[CNT_W-1:0];
            if (wr_ctrl) ctrl    <= ctrl_t'(bus_wdata[2:0]);
            if (wr_ien)  ien     <= bus_wdata[0];
            if (expire)                      flag <= 1'b1;
            else if (wr_flag && bus_wdata[0]) flag <= 1'b0;
            wd_div  <= wr_div  | (wd_div  & ~(wr_wdone & bus_wdata[WD_DIV_BIT]));
            wd_per  <= wr_per  | (wd_per  & ~(wr_wdone & bus_wdata[WD_PERIOD_BIT]));
            wd_ctrl <= wr_ctrl | (wd_ctrl & ~(wr_wdone & bus_wdata[WD_CTRL_BIT]));
        end
    end

    // Read-back mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_DIV):    bus_rdata[PRE_W-1:0] = div_buf;
            AW'(OFS_PERIOD): bus_rdata[CNT_W-1:0] = per_buf;
            AW'(OFS_CTRL):   bus_rdata[2:0]       = ctrl;
            AW'(OFS_FLAG):   bus_rdata[0]         = flag;
            AW'(OFS_IEN):    bus_rdata[0]         = ien;
            AW'(OFS_WDONE): begin
                bus_rdata[WD_DIV_BIT]    = wd_div;
                bus_rdata[WD_PERIOD_BIT] = wd_per;
                bus_rdata[WD_CTRL_BIT]   = wd_ctrl;
            end
            default:         bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tick_timer_prescaler.sv
// Prescaler: counts enabled timer cycles down from the divisor and emits a
// one-cycle tick at zero, then reloads. Holds its value while not running.
module tick_timer_prescaler #(
    parameter int PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tclk_en,
    input  logic             load,
    input  logic [PRE_W-1:0] load_val,
    input  logic [PRE_W-1:0] reload_val,
    output logic             tick,
    output logic [PRE_W-1:0] count
);
    assign tick = run && tclk_en && (count == '0);

    // Divisor down-counter with bus load priority
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (load)             count <= load_val;
        else if (tick)             count <= reload_val;
        else if (run && tclk_en)   count <= count - 1'b1;
    end
endmodule

// File: rtl/tick_timer_period.sv
// Period counter: decrements on each tick while running, signals expiry on the
// tick that takes it from 1 to 0, then reloads (interval) or rests at 0.
module tick_timer_period #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             interval,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    logic step;
    assign step   = tick && run;
    assign expire = step && (count == CNT_W'(1));

    // Tick counter with load priority over decrement and reload
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (load)                   count <= load_val;
        else if (expire)                 count <= interval ? reload_val : '0;
        else if (step && count != '0)    count <= count - 1'b1;
    end
endmodule

// File: rtl/per_core_tick_timer.sv
// Top of the per-core tick timer: register file, prescaler and period counter.
// Assumes the timer clock is provided as an enable in the bus clock domain.
module per_core_tick_timer #(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int PRE_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tclk_en,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    import tick_timer_pkg::*;
    localparam int CNT_W = DW - 1;

    logic             div_load, per_load, tick, expire, flag, ien;
    logic [PRE_W-1:0] div_buf, div_cnt;
    logic [CNT_W-1:0] per_buf, per_cnt;
    ctrl_t            ctrl;

    tick_timer_regs #(.DW(DW), .AW(AW), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire(expire),
        .div_load(div_load), .per_load(per_load), .div_buf(div_buf),
        .per_buf(per_buf), .ctrl(ctrl), .flag(flag), .ien(ien)
    );

    tick_timer_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(ctrl.tick_run), .tclk_en(tclk_en),
        .load(div_load), .load_val(bus_wdata[PRE_W-1:0]), .reload_val(div_buf),
        .tick(tick), .count(div_cnt)
    );

    tick_timer_period #(.CNT_W(CNT_W)) u_per (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl.per_run),
        .interval(ctrl.interval), .load(per_load),
        .load_val(bus_wdata[CNT_W-1:0]), .reload_val(per_buf),
        .expire(expire), .count(per_cnt)
    );

    assign irq = flag & ien;
endmodule

// File: rtl/tick_timer_chk.sv
// Checker for the per-core tick timer, attached to the top by bind.
module tick_timer_chk #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int PRE_W = 32,
    parameter int CNT_W = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tclk_en,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [2:0]       ctrl,
    input logic             tick,
    input logic             expire,
    input logic             div_load,
    input logic             per_load,
    input logic [PRE_W-1:0] div_cnt,
    input logic [CNT_W-1:0] per_cnt,
    input logic [CNT_W-1:0] per_buf,
    input logic             flag
);
    // R7
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ctrl[0] || !tclk_en) && !div_load) |=> $stable(div_cnt));
    // R6
    per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!tick || !ctrl[1]) && !per_load) |=> $stable(per_cnt));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl[2] && !per_load) |=> (per_cnt == $past(per_buf)));
    // R4
    oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl[2] && !per_load) |=> (per_cnt == '0));
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_cnt == '0 && !per_load) |=> (per_cnt == '0));
    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(bus_wr && bus_addr == AW'(8'h30) && bus_wdata[0]));
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(expire));
endmodule

bind per_core_tick_timer tick_timer_chk #(.AW(AW), .DW(DW), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tclk_en(tclk_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctrl(ctrl), .tick(tick),
    .expire(expire), .div_load(div_load), .per_load(per_load),
    .div_cnt(div_cnt), .per_cnt(per_cnt), .per_buf(per_buf), .flag(flag)
);

// File: tb/per_core_tick_timer_bench.sv
module per_core_tick_timer_bench;
    localparam int CLK_P = 10;
    localparam logic [7:0] A_DIV = 8'h00, A_PER = 8'h08, A_CTRL = 8'h20,
                           A_FLAG = 8'h30, A_IEN = 8'h34, A_WD = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tclk_en = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0, errors = 0, nr, hits, p;
    int rises [3];
    logic [31:0] rv;
    bit done = 1'b0;

    per_core_tick_timer u_per_core_tick_timer (
        .clk(clk), .rst_n(rst_n), .tclk_en(tclk_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic count_irq(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin step(); if (irq) h++; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state of every register and irq
        foreach (rises[i]) rises[i] = 0;
        rd(A_DIV, rv);  chk("R1 div", rv, 0);
        rd(A_PER, rv);  chk("R1 period", rv, 0);
        rd(A_CTRL, rv); chk("R1 ctrl", rv, 0);
        rd(A_FLAG, rv); chk("R1 flag", rv, 0);
        rd(A_IEN, rv);  chk("R1 ien", rv, 0);
        rd(A_WD, rv);   chk("R1 wdone", rv, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R9: write-applied flags set and cleared by writing 1
        wr(A_DIV, 0);  rd(A_WD, rv); chk("R9 div flag", rv, 32'h1);
        wr(A_PER, 0);  rd(A_WD, rv); chk("R9 period flag", rv, 32'h3);
        wr(A_CTRL, 0); rd(A_WD, rv); chk("R9 ctrl flag", rv, 32'hB);
        wr(A_IEN, 0);  rd(A_WD, rv); chk("R9 ien no flag", rv, 32'hB);
        wr(A_WD, 2);   rd(A_WD, rv); chk("R9 w1c one", rv, 32'h9);
        wr(A_WD, 32'hFF); rd(A_WD, rv); chk("R9 w1c all", rv, 32'h0);

        // R2 R4 R5: sweep divisor, period and mode
        for (int n = 0; n < 4; n++) begin
            for (int c = 1; c < 5; c++) begin
                for (int iv = 0; iv < 2; iv++) begin
                    p = c * (n + 1);
                    if (p < 2) continue;
                    wr(A_CTRL, 0); wr(A_DIV, n); wr(A_PER, 32'h8000_0000 | c);
                    wr(A_IEN, 1); wr(A_FLAG, 1);
                    wr(A_CTRL, (iv != 0) ? 32'h7 : 32'h3);
                    nr = 0;
                    foreach (rises[i]) rises[i] = 0;
                    for (int k = 1; k <= 3 * p; k++) begin
                        step();
                        bus_wr = 1'b0;
                        if (irq) begin
                            if (nr < 3) rises[nr] = k;
                            nr++;
                            if (iv != 0) begin
                                bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 1;
                            end
                        end
                    end
                    if (bus_wr) begin step(); bus_wr = 1'b0; end
                    chk("R2 first interrupt delay", rises[0], p);
                    if (iv != 0) begin
                        chk("R5 interrupt count", nr, 3);
                        chk("R5 second interrupt", rises[1], 2 * p);
                        chk("R5 third interrupt", rises[2], 3 * p);
                    end else begin
                        chk("R4 irq held high", nr, 2 * p + 1);
                        wr(A_FLAG, 1);
                        count_irq(2 * p, hits);
                        chk("R4 no second interrupt", hits, 0);
                    end
                end
            end
        end

        // R6: freeze both counters, resume from held count
        wr(A_CTRL, 0); wr(A_DIV, 0); wr(A_PER, 32'h8000_0005); wr(A_FLAG, 1);
        wr(A_CTRL, 3);
        step(); step();
        wr(A_CTRL, 0);
        count_irq(10, hits);
        chk("R6 frozen no irq", hits, 0);
        rd(A_FLAG, rv); chk("R6 frozen flag", rv, 0);
        wr(A_CTRL, 3);
        step(); chk("R6 resume early", {31'b0, irq}, 0);
        step(); chk("R6 resume at held count", {31'b0, irq}, 1);

        // R7: no counting while tclk_en is low
        tclk_en = 1'b0;
        wr(A_CTRL, 0); wr(A_DIV, 1); wr(A_PER, 32'h8000_0002); wr(A_FLAG, 1);
        wr(A_CTRL, 3);
        count_irq(20, hits);
        chk("R7 gated no irq", hits, 0);
        tclk_en = 1'b1;
        step(); step(); step();
        chk("R7 before expiry", {31'b0, irq}, 0);
        step();
        chk("R7 expiry after enable", {31'b0, irq}, 1);

        // R8: enable gates irq, flag cleared by writing 1
        wr(A_CTRL, 0); wr(A_IEN, 0); wr(A_DIV, 0); wr(A_PER, 32'h8000_0002);
        wr(A_FLAG, 1); wr(A_CTRL, 3);
        count_irq(4, hits);
        chk("R8 masked irq", hits, 0);
        rd(A_FLAG, rv); chk("R8 flag set while masked", rv, 1);
        wr(A_IEN, 1);  chk("R8 irq on enable", {31'b0, irq}, 1);
        wr(A_FLAG, 1); chk("R8 irq after clear", {31'b0, irq}, 0);

        // R3 R10: buffer-only write, idle zero counter, update request
        wr(A_CTRL, 0); wr(A_PER, 32'h8000_0000); wr(A_PER, 3); wr(A_FLAG, 1);
        wr(A_CTRL, 7);
        count_irq(20, hits);
        chk("R10 zero counter idle", hits, 0);
        rd(A_PER, rv); chk("R3 buffer readback", rv, 3);
        wr(A_PER, 32'h8000_0003);
        step(); step(); chk("R3 before loaded expiry", {31'b0, irq}, 0);
        step();         chk("R3 loaded count expiry", {31'b0, irq}, 1);
        wr(A_CTRL, 0); wr(A_PER, 32'hFFFF_FFFF);
        rd(A_PER, rv); chk("R3 bit31 reads zero", rv, 32'h7FFF_FFFF);

        finish_run();
    end
endmodule